// File: doc/BRIEF.md
# Multiplexer Routing Switch Box

This block is one routing switch of a small fabric of programmable logic that is itself built out of ordinary synthesizable logic. Every routing wire that would be bidirectional in a transistor-level fabric is split here into an incoming wire and an outgoing wire. Each of the four sides carries short channels, which reach the neighbouring switch, and long channels, which reach the switch two positions away. Every outgoing wire is driven by a configurable selector. Each input of the attached logic cell is picked from the full set of incoming wires.

The selector settings live in a serial chain of flip-flops, one bit per select bit. The chain is loaded by shifting with an enable and can be daisy-chained through `cfg_sdo_o` to the next switch or cell. While a load is in progress, every outgoing wire is held low so that half-loaded settings cannot form loops in the fabric. All routing paths are combinational, from `rt_in_i` and `lc_res_i` to `rt_out_o` and `lc_arg_o`.

Wires are numbered `idx = side*8 + class*4 + chan`. Sides are 0..3 in clockwise order, class is 0 for short and 1 for long, and chan is 0..3. The same numbering is used for `rt_in_i` and `rt_out_o`.

Top module: `swbox_mux_router`

## Requirements
- R1: When `cfg_shift_i` is high at a rising clock edge, the chain moves one place: bit 0 takes `cfg_sdi_i` and bit i takes bit i-1. `cfg_sdo_o` shows bit 157, so a bit appears there 158 shifts after it entered. The select field for outgoing wire w sits at bits [4w+3:4w]. The field for cell input k sits at bits [128+5k+4:128+5k].
- R2: When `cfg_shift_i` is low, the chain keeps its contents whatever `cfg_sdi_i` does, so the routing and `cfg_sdo_o` stay unchanged.
- R3: Reset clears the whole chain. Every field then reads 0 and `cfg_sdo_o` is 0.
- R4: Codes 0, 1 and 2 on outgoing wire (s, class, chan) select the incoming wire of the same class and chan from side (s+1)%4, (s+2)%4 and (s+3)%4 respectively.
- R5: Codes 3, 4 and 5 select the paired wire, which has the opposite class and the same chan, from side (s+1)%4, (s+2)%4 and (s+3)%4 respectively.
- R6: Codes 6 to 9 select logic cell outputs `lc_res_i[0]` to `lc_res_i[3]`.
- R7: Codes 10 to 15 drive the outgoing wire to 0.
- R8: Cell input k (`lc_arg_o[k]`) equals `rt_in_i[sel]`, where sel is a 5-bit field: side in bits 4:3, the long flag in bit 2 and chan in bits 1:0.
- R9: While `cfg_shift_i` is high, all of `rt_out_o` is 0. `lc_arg_o` is not affected.
- R10: Routing is combinational. A change on `rt_in_i` or `lc_res_i` appears on the outputs without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration chain |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_shift_i | input | 1 | Shift enable for the configuration chain |
| cfg_sdi_i | input | 1 | Serial configuration data in |
| cfg_sdo_o | output | 1 | Serial configuration data out (last chain bit) |
| rt_in_i | input | 32 | Incoming routing wires, indexed side*8+class*4+chan |
| rt_out_o | output | 32 | Outgoing routing wires, same indexing |
| lc_res_i | input | 4 | Outputs of the attached logic cell |
| lc_arg_o | output | 6 | Inputs to the attached logic cell |

## Verification
The hardest state to reach from the ports is a chain where every output code, including every unused code, sits on many wires at once, with several independent cell-input selects. Reaching it takes 158 serial shifts, and each check of the contents has to see the whole routing at the same time. The bench loads full random configurations and a few directed ones: all codes 10 to 15, codes cycling through every value, and the all-zero reset state. It then applies random wire and cell patterns and compares every output against a model of the code table. While each new configuration is shifted in, the bits leaving on `cfg_sdo_o` are compared with the previous configuration, which checks the chain order and the field layout from the ports alone.

// File: rtl/swbox_pkg.sv
package swbox_pkg;
  // number of sides of a switch box; the code table assumes four
  localparam int SIDES = 4;

  // flat wire index for (side, class, channel)
  function automatic int wire_idx(input int side, input int cls, input int ch,
                                  input int chans);
    return side * 2 * chans + cls * chans + ch;
  endfunction
endpackage

// File: rtl/swbox_rst_sync.sv
module swbox_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/swbox_cfg_chain.sv
module swbox_cfg_chain #(
  parameter int LEN = 158
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           shift_i,
  input  logic           sdi_i,
  output logic [LEN-1:0] bits_o,
  output logic           sdo_o
);
  logic [LEN-1:0] chain_q;
  logic [LEN-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[LEN-2:0], sdi_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       chain_q <= '0;
    else if (shift_i) chain_q <= chain_d;
  end

  assign bits_o = chain_q;
  assign sdo_o  = chain_q[LEN-1];
endmodule

// File: rtl/swbox_out_sel.sv
module swbox_out_sel
  import swbox_pkg::*;
#(
  parameter int CHANS     = 4,
  parameter int CELL_OUTS = 4,
  parameter int SEL_W     = 4,
  parameter int SIDE      = 0,
  parameter int CLS       = 0,
  parameter int CH        = 0,
  localparam int WIRES    = SIDES * 2 * CHANS,
  localparam int NCAND    = 2 * (SIDES - 1) + CELL_OUTS
) (
  input  logic [WIRES-1:0]     rt_in_i,
  input  logic [CELL_OUTS-1:0] lc_res_i,
  input  logic [SEL_W-1:0]     sel_i,
  output logic                 y_o
);
  logic [NCAND-1:0] cand;

  for (genvar k = 0; k < SIDES - 1; k++) begin : g_side
    localparam int SRC_SIDE = (SIDE + k + 1) % SIDES;
    localparam int SAME_IDX = wire_idx(SRC_SIDE, CLS, CH, CHANS);
    localparam int PAIR_IDX = wire_idx(SRC_SIDE, 1 - CLS, CH, CHANS);
    assign cand[k]             = rt_in_i[SAME_IDX];
    assign cand[SIDES - 1 + k] = rt_in_i[PAIR_IDX];
  end

  for (genvar k = 0; k < CELL_OUTS; k++) begin : g_cell
    assign cand[2 * (SIDES - 1) + k] = lc_res_i[k];
  end

  always_comb begin
    y_o = 1'b0;
    for (int i = 0; i < NCAND; i++) begin
      if (sel_i == SEL_W'(i)) y_o = cand[i];
    end
  end
endmodule

// File: rtl/swbox_cell_sel.sv
module swbox_cell_sel #(
  parameter int WIRES = 32,
  parameter int SEL_W = 5
) (
  input  logic [WIRES-1:0] rt_in_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             y_o
);
  always_comb begin
    y_o = 1'b0;
    for (int i = 0; i < WIRES; i++) begin
      if (sel_i == SEL_W'(i)) y_o = rt_in_i[i];
    end
  end
endmodule

// File: rtl/swbox_mux_router.sv
module swbox_mux_router
  import swbox_pkg::*;
#(
  parameter int CHANS     = 4,
  parameter int CELL_OUTS = 4,
  parameter int CELL_INS  = 6,
  localparam int WIRES    = SIDES * 2 * CHANS,
  localparam int NCAND    = 2 * (SIDES - 1) + CELL_OUTS,
  localparam int OSEL_W   = $clog2(NCAND + 1),
  localparam int ISEL_W   = $clog2(WIRES),
  localparam int OUT_BITS = WIRES * OSEL_W,
  localparam int CFG_LEN  = OUT_BITS + CELL_INS * ISEL_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_shift_i,
  input  logic                 cfg_sdi_i,
  output logic                 cfg_sdo_o,
  input  logic [WIRES-1:0]     rt_in_i,
  output logic [WIRES-1:0]     rt_out_o,
  input  logic [CELL_OUTS-1:0] lc_res_i,
  output logic [CELL_INS-1:0]  lc_arg_o
);
  logic               rst_q_n;
  logic [CFG_LEN-1:0] cfg_q;
  logic [WIRES-1:0]   route_raw;

  swbox_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  swbox_cfg_chain #(.LEN(CFG_LEN)) u_chain (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .shift_i (cfg_shift_i),
    .sdi_i   (cfg_sdi_i),
    .bits_o  (cfg_q),
    .sdo_o   (cfg_sdo_o)
  );

  for (genvar w = 0; w < WIRES; w++) begin : g_out
    localparam int W_SIDE = w / (2 * CHANS);
    localparam int W_CLS  = (w / CHANS) % 2;
    localparam int W_CH   = w % CHANS;
    swbox_out_sel #(
      .CHANS     (CHANS),
      .CELL_OUTS (CELL_OUTS),
      .SEL_W     (OSEL_W),
      .SIDE      (W_SIDE),
      .CLS       (W_CLS),
      .CH        (W_CH)
    ) u_osel (
      .rt_in_i  (rt_in_i),
      .lc_res_i (lc_res_i),
      .sel_i    (cfg_q[w*OSEL_W +: OSEL_W]),
      .y_o      (route_raw[w])
    );
  end

  // outgoing wires are quiet while the chain is shifting
  assign rt_out_o = route_raw & {WIRES{~cfg_shift_i}};

  for (genvar k = 0; k < CELL_INS; k++) begin : g_arg
    swbox_cell_sel #(.WIRES(WIRES), .SEL_W(ISEL_W)) u_isel (
      .rt_in_i (rt_in_i),
      .sel_i   (cfg_q[OUT_BITS + k*ISEL_W +: ISEL_W]),
      .y_o     (lc_arg_o[k])
    );
  end
endmodule

// File: rtl/swbox_mux_router_chk.sv
module swbox_mux_router_chk #(
  parameter int WIRES     = 32,
  parameter int CELL_INS  = 6,
  parameter int NCAND     = 10,
  parameter int OSEL_W    = 4,
  parameter int ISEL_W    = 5,
  parameter int CFG_LEN   = 158
) (
  input logic               clk,
  input logic               rst_q_n,
  input logic               cfg_shift_i,
  input logic               cfg_sdi_i,
  input logic [CFG_LEN-1:0] cfg_q,
  input logic [WIRES-1:0]   rt_in_i,
  input logic [WIRES-1:0]   rt_out_o,
  input logic [CELL_INS-1:0] lc_arg_o
);
  localparam int OUT_BITS = WIRES * OSEL_W;

  AST_QUIET_WHILE_LOADING: assert property (@(posedge clk) disable iff (!rst_q_n)
    cfg_shift_i |-> (rt_out_o == '0)); // R9

  AST_CHAIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_q_n)
    !cfg_shift_i |=> $stable(cfg_q)); // R2

  AST_CHAIN_STEP: assert property (@(posedge clk) disable iff (!rst_q_n)
    cfg_shift_i |=> (cfg_q[CFG_LEN-1:1] == $past(cfg_q[CFG_LEN-2:0])) &&
                    (cfg_q[0] == $past(cfg_sdi_i))); // R1

  for (genvar k = 0; k < CELL_INS; k++) begin : g_arg_chk
    AST_CELL_ARG_PICK: assert property (@(posedge clk) disable iff (!rst_q_n)
      lc_arg_o[k] == rt_in_i[cfg_q[OUT_BITS + k*ISEL_W +: ISEL_W]]); // R8
  end

  for (genvar w = 0; w < WIRES; w++) begin : g_out_chk
    AST_UNUSED_CODE_LOW: assert property (@(posedge clk) disable iff (!rst_q_n)
      (!cfg_shift_i && (int'(cfg_q[w*OSEL_W +: OSEL_W]) >= NCAND)) |-> !rt_out_o[w]); // R7
  end
endmodule

bind swbox_mux_router swbox_mux_router_chk #(
  .WIRES    (WIRES),
  .CELL_INS (CELL_INS),
  .NCAND    (NCAND),
  .OSEL_W   (OSEL_W),
  .ISEL_W   (ISEL_W),
  .CFG_LEN  (CFG_LEN)
) u_chk (
  .clk         (clk),
  .rst_q_n     (rst_q_n),
  .cfg_shift_i (cfg_shift_i),
  .cfg_sdi_i   (cfg_sdi_i),
  .cfg_q       (cfg_q),
  .rt_in_i     (rt_in_i),
  .rt_out_o    (rt_out_o),
  .lc_arg_o    (lc_arg_o)
);

// File: tb/swbox_mux_router_tb_top.sv
module swbox_mux_router_tb_top;
  localparam int LEN = 158;

  logic        clk;
  logic        rst_n;
  logic        cfg_shift_i;
  logic        cfg_sdi_i;
  logic        cfg_sdo_o;
  logic [31:0] rt_in_i;
  logic [31:0] rt_out_o;
  logic [3:0]  lc_res_i;
  logic [5:0]  lc_arg_o;

  int checks;
  int errors;
  bit done;

  swbox_mux_router dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_shift_i (cfg_shift_i),
    .cfg_sdi_i   (cfg_sdi_i),
    .cfg_sdo_o   (cfg_sdo_o),
    .rt_in_i     (rt_in_i),
    .rt_out_o    (rt_out_o),
    .lc_res_i    (lc_res_i),
    .lc_arg_o    (lc_arg_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic exp_wire(input logic [LEN-1:0] c, input logic [31:0] ri,
                                    input logic [3:0] co, input int w);
    int s    = w / 8;
    int cl   = (w / 4) % 2;
    int ch   = w % 4;
    int code = int'(c[4*w +: 4]);
    if (code < 3)       return ri[((s + code + 1) % 4) * 8 + cl * 4 + ch];
    else if (code < 6)  return ri[((s + code - 2) % 4) * 8 + (1 - cl) * 4 + ch];
    else if (code < 10) return co[code - 6];
    else                return 1'b0;
  endfunction

  function automatic string code_req(input logic [LEN-1:0] c, input int w);
    int code = int'(c[4*w +: 4]);
    if (code < 3)       return "R4";
    else if (code < 6)  return "R5";
    else if (code < 10) return "R6";
    else                return "R7";
  endfunction

  function automatic logic [LEN-1:0] rand_cfg();
    logic [LEN-1:0] c;
    for (int w = 0; w < 32; w++) c[4*w +: 4] = 4'($urandom % 16);
    for (int k = 0; k < 6; k++) c[128 + 5*k +: 5] = 5'($urandom % 32);
    return c;
  endfunction

  task automatic check_bit(input logic act, input logic exp, input string req,
                           input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // R10: inputs change between edges and outputs are checked before any edge
  task automatic run_vectors(input logic [LEN-1:0] c, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rt_in_i  = $urandom;
      lc_res_i = 4'($urandom % 16);
      #2;
      for (int w = 0; w < 32; w++)
        check_bit(rt_out_o[w], exp_wire(c, rt_in_i, lc_res_i, w), code_req(c, w),
                  $sformatf("R10 rt_out[%0d]", w));
      for (int k = 0; k < 6; k++)
        check_bit(lc_arg_o[k], rt_in_i[c[128 + 5*k +: 5]], "R8",
                  $sformatf("lc_arg[%0d]", k));
    end
  endtask

  // shifts c in MSB first; the bits leaving must be the old contents (R1)
  task automatic load_cfg(input logic [LEN-1:0] c, input logic [LEN-1:0] prev);
    for (int i = 0; i < LEN; i++) begin
      @(negedge clk);
      cfg_shift_i = 1'b1;
      cfg_sdi_i   = c[LEN-1-i];
      rt_in_i     = $urandom;
      lc_res_i    = 4'($urandom % 16);
      #2;
      check_bit(cfg_sdo_o, prev[LEN-1-i], "R1", $sformatf("sdo shift %0d", i));
      checks++;
      if (rt_out_o !== 32'h0) begin
        errors++;
        $display("FAIL R9 rt_out while loading actual=%h expected=0", rt_out_o);
      end
    end
    @(negedge clk);
    cfg_shift_i = 1'b0;
  endtask

  initial begin
    logic [LEN-1:0] cur;
    logic [LEN-1:0] nxt;
    checks = 0;
    errors = 0;
    done   = 0;
    void'($urandom(32'h1a2b3c4d));
    rst_n = 1'b0;
    cfg_shift_i = 1'b0;
    cfg_sdi_i = 1'b0;
    rt_in_i = '0;
    lc_res_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R3: cleared chain, all fields zero
    cur = '0;
    #2;
    check_bit(cfg_sdo_o, 1'b0, "R3", "sdo after reset");
    run_vectors(cur, 6);

    // directed: every wire on an unused code (R7), cycling codes
    nxt = '0;
    for (int w = 0; w < 32; w++) nxt[4*w +: 4] = 4'(10 + (w % 6));
    for (int k = 0; k < 6; k++) nxt[128 + 5*k +: 5] = 5'(31 - k);
    load_cfg(nxt, cur); cur = nxt;
    run_vectors(cur, 6);

    nxt = '0;
    for (int w = 0; w < 32; w++) nxt[4*w +: 4] = 4'(w % 16);
    for (int k = 0; k < 6; k++) nxt[128 + 5*k +: 5] = 5'(k * 5);
    load_cfg(nxt, cur); cur = nxt;
    run_vectors(cur, 6);

    nxt = '0;
    for (int w = 0; w < 32; w++) nxt[4*w +: 4] = 4'((w + 3) % 10);
    for (int k = 0; k < 6; k++) nxt[128 + 5*k +: 5] = 5'(8 * (k % 4) + 4 + (k % 4));
    load_cfg(nxt, cur); cur = nxt;
    run_vectors(cur, 6);

    // random configurations
    for (int r = 0; r < 6; r++) begin
      nxt = rand_cfg();
      load_cfg(nxt, cur); cur = nxt;
      run_vectors(cur, 10);
      // R2: idle with data toggling must not disturb the chain
      for (int j = 0; j < 20; j++) begin
        @(negedge clk);
        cfg_sdi_i = 1'($urandom % 2);
        #2;
        check_bit(cfg_sdo_o, cur[LEN-1], "R2", "sdo while idle");
      end
      run_vectors(cur, 4);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule